// File: doc/BRIEF.md
# Delayed ADC Pre-Trigger Generator

This block turns a single trigger event into a set of single-cycle pre-trigger pulses, one per slot, that start analog-to-digital conversions. The trigger comes from one of several hardware inputs or from a software write. The hardware inputs are synchronized and edge-detected. Every trigger event restarts a 16-bit counter. The counter runs up to a programmable modulus and then holds.

Each implemented slot has three bits in one control word:
- an enable bit;
- a timing bit, which picks between firing right after the trigger (bypass) and firing when the counter reaches the slot's own delay value (delayed);
- a chaining bit, which makes the slot fire on the conversion-complete input of the slot below it.

Chaining lets a sequence of conversions walk down a set of result registers. Only the head of the chain is started by the trigger. Software programs the block through a simple synchronous register bus with combinational read data.

Top module: `pretrig_gen`

## Requirements
- R1: The slot control word is at address 0. Enable bits are in [7:0], timing bits in [15:8] and chaining bits in [23:16], with slot n at offset n in each field. Bits [31:24] always read 0. Bits for slots at or above NUM_SLOTS read 0 and are not stored. The word resets to 0.
- R2: A slot whose enable bit is 0 never pulses, whatever its timing or chaining bits and whatever triggers or conversion-complete inputs arrive.
- R3: When address 1 bit 8 is 0, the hardware input indexed by address 1 bits [1:0] is the trigger. It passes through two synchronizing flops and a rising-edge detector. An enabled bypass slot (timing 0, chaining 0) pulses for exactly one cycle, on the third rising clock edge after the input goes high. Edges on inputs that are not selected do nothing.
- R4: When address 1 bit 8 is 1, writing 1 to bit 0 of address 2 is a trigger. Enabled bypass slots pulse in the cycle after the write cycle. Address 2 always reads 0. Software writes have no effect in hardware mode, and hardware edges have no effect in software mode.
- R5: The delay for slot n is at address 4+n (16 bits). An enabled slot with timing bit 1 and chaining bit 0 pulses once, in the cycle after the counter equals its delay. The counter reads 0 in the cycle after the trigger, so for a software trigger the pulse comes d+2 cycles after the write cycle. A new trigger restarts the count.
- R6: The modulus is at address 3 and resets to 0xFFFF. The counter stops after the cycle in which it equals the modulus. A delay equal to the modulus fires. A delay above the modulus never fires.
- R7: An enabled slot n with its chaining bit set pulses in the cycle after conversion-complete input n-1 is high. Slot 0 uses input NUM_SLOTS-1. The trigger itself never fires a chained slot.
- R8: Each delayed or chained slot fires at most once per trigger event. Further matches or conversion-complete pulses are ignored until the next trigger.
- R9: A conversion-complete input that arrives in the same cycle as a trigger belongs to the earlier event. It fires the chained slot only if that slot is still waiting from the earlier event. Either way, the slot is waiting again afterwards, for the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwTrigIn | input | NUM_TRIG | Asynchronous hardware trigger candidates |
| convDone | input | NUM_SLOTS | Conversion-complete strobes, one per slot |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write when high, with busSel |
| busAddr | input | ADDR_W | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| preTrig | output | NUM_SLOTS | Single-cycle pre-trigger pulses |

## Verification
A trigger and a conversion-complete strobe can land in the same clock cycle. That cycle both re-arms a chained slot and might fire it. The bench forces this by driving the software trigger write and the conversion-complete input together. It does this twice: once while the chained slot is still waiting from an earlier event, and once after the slot has already fired. The scoreboard expects a pulse only in the first case, and expects the slot to answer the next conversion-complete afterwards in both cases. The bench also fires a second trigger while a delayed slot is still counting, and checks that only the delay measured from the newer trigger produces a pulse.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;
  localparam int BUS_W    = 32;
  localparam int CTRL_ADR = 0;
  localparam int CFG_ADR  = 1;
  localparam int SWT_ADR  = 2;
  localparam int MOD_ADR  = 3;
  localparam int DLY_BASE = 4;
  localparam int EN_LSB    = 0;
  localparam int SEL_LSB   = 8;
  localparam int CHAIN_LSB = 16;
  localparam int SWMODE_BIT = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic trigEvt;   // one accepted trigger event this cycle
    logic modWrite;  // modulus rewritten this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/pretrig_edge.sv
module pretrig_edge #(
  parameter int NUM_TRIG = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIG-1:0] rawIn,
  output logic [NUM_TRIG-1:0] riseOut
);
  logic [NUM_TRIG-1:0] meta, stable, last;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta   <= '0;
      stable <= '0;
      last   <= '0;
    end else begin
      meta   <= rawIn;
      stable <= meta;
      last   <= stable;
    end
  end

  assign riseOut = stable & ~last;
endmodule

// File: rtl/pretrig_ctl.sv
module pretrig_ctl
  import pretrig_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_TRIG  = 4,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_TRIG-1:0]              hwRise,
  input  logic                             busSel,
  input  logic                             busWrite,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [BUS_W-1:0]                 busWdata,
  output logic [BUS_W-1:0]                 busRdata,
  output logic [NUM_SLOTS-1:0]             slotEn,
  output logic [NUM_SLOTS-1:0]             slotSel,
  output logic [NUM_SLOTS-1:0]             slotChain,
  output logic [CNT_W-1:0]                 modulus,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0]  slotDelay,
  output ctlStrobe_t                       strobe
);
  localparam int TSEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [NUM_SLOTS-1:0]            enQ, selQ, chainQ;
  logic                            swModeQ;
  logic [TSEL_W-1:0]               tselQ;
  logic [CNT_W-1:0]                modQ;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] dlyQ;
  logic                            wrEn, swHit, hwHit;
  logic                            unusedWdata;

  assign wrEn        = busSel & busWrite;
  assign unusedWdata = ^busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= '0;
      selQ    <= '0;
      chainQ  <= '0;
      swModeQ <= 1'b0;
      tselQ   <= '0;
      modQ    <= '1;
    end else if (wrEn) begin
      if (busAddr == ADDR_W'(CTRL_ADR)) begin
        enQ    <= busWdata[EN_LSB +: NUM_SLOTS];
        selQ   <= busWdata[SEL_LSB +: NUM_SLOTS];
        chainQ <= busWdata[CHAIN_LSB +: NUM_SLOTS];
      end
      if (busAddr == ADDR_W'(CFG_ADR)) begin
        swModeQ <= busWdata[SWMODE_BIT];
        tselQ   <= busWdata[TSEL_W-1:0];
      end
      if (busAddr == ADDR_W'(MOD_ADR)) modQ <= busWdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyQ <= '0;
    end else if (wrEn) begin
      for (int n = 0; n < NUM_SLOTS; n++) begin
        if (busAddr == ADDR_W'(DLY_BASE + n)) dlyQ[n] <= busWdata[CNT_W-1:0];
      end
    end
  end

  // trigger selection: software strobe is self-clearing (never stored)
  assign swHit = wrEn && (busAddr == ADDR_W'(SWT_ADR)) && busWdata[0];
  assign hwHit = (int'(tselQ) < NUM_TRIG) ? hwRise[tselQ] : 1'b0;

  assign strobe.trigEvt  = swModeQ ? swHit : hwHit;
  assign strobe.modWrite = wrEn && (busAddr == ADDR_W'(MOD_ADR));

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(CTRL_ADR)) begin
      busRdata[EN_LSB +: NUM_SLOTS]    = enQ;
      busRdata[SEL_LSB +: NUM_SLOTS]   = selQ;
      busRdata[CHAIN_LSB +: NUM_SLOTS] = chainQ;
    end
    if (busAddr == ADDR_W'(CFG_ADR)) begin
      busRdata[SWMODE_BIT]   = swModeQ;
      busRdata[TSEL_W-1:0]   = tselQ;
    end
    if (busAddr == ADDR_W'(MOD_ADR)) busRdata[CNT_W-1:0] = modQ;
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (busAddr == ADDR_W'(DLY_BASE + n)) busRdata[CNT_W-1:0] = dlyQ[n];
    end
  end

  assign slotEn    = enQ;
  assign slotSel   = selQ;
  assign slotChain = chainQ;
  assign modulus   = modQ;
  assign slotDelay = dlyQ;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(CTRL_ADR)) |-> (busRdata[31:24] == 8'h00)); // R1
  AST_SWT_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(SWT_ADR)) |-> (busRdata == '0)); // R4
endmodule

// File: rtl/pretrig_dp.sv
module pretrig_dp
  import pretrig_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctlStrobe_t                       strobe,
  input  logic [NUM_SLOTS-1:0]             convDone,
  input  logic [NUM_SLOTS-1:0]             slotEn,
  input  logic [NUM_SLOTS-1:0]             slotSel,
  input  logic [NUM_SLOTS-1:0]             slotChain,
  input  logic [CNT_W-1:0]                 modulus,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0]  slotDelay,
  output logic [NUM_SLOTS-1:0]             preTrig
);
  logic [CNT_W-1:0]     cntQ;
  logic                 runQ;
  logic [NUM_SLOTS-1:0] armedQ, fire, dlyHit, armNext;
  logic [NUM_SLOTS-1:0] pulseQ;
  logic                 unusedStrobe;

  assign unusedStrobe = strobe.modWrite;

  // shared counter: restarts on every trigger, holds after the modulus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      runQ <= 1'b0;
    end else if (strobe.trigEvt) begin
      cntQ <= '0;
      runQ <= 1'b1;
    end else if (runQ) begin
      if (cntQ >= modulus) runQ <= 1'b0;
      else                 cntQ <= cntQ + 1'b1;
    end
  end

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    localparam int PREV = (n == 0) ? NUM_SLOTS - 1 : n - 1;

    assign dlyHit[n] = runQ && (cntQ == slotDelay[n]) && (slotDelay[n] <= modulus);

    always_comb begin
      if (!slotEn[n])        fire[n] = 1'b0;
      else if (slotChain[n]) fire[n] = armedQ[n] & convDone[PREV];
      else if (slotSel[n])   fire[n] = armedQ[n] & dlyHit[n];
      else                   fire[n] = strobe.trigEvt;
    end

    // a trigger re-arms; otherwise a firing disarms until the next trigger
    assign armNext[n] = strobe.trigEvt ? (slotEn[n] & (slotChain[n] | slotSel[n]))
                                       : (armedQ[n] & ~fire[n]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armedQ[n] <= 1'b0;
        pulseQ[n] <= 1'b0;
      end else begin
        armedQ[n] <= armNext[n];
        pulseQ[n] <= fire[n];
      end
    end

    AST_SLOT_OFF: assert property (@(posedge clk) disable iff (!rstN)
      !slotEn[n] |=> !preTrig[n]); // R2
    AST_CHAIN_SRC: assert property (@(posedge clk) disable iff (!rstN)
      (slotEn[n] && slotChain[n] && !convDone[PREV]) |=> !preTrig[n]); // R7
    AST_BYPASS_SRC: assert property (@(posedge clk) disable iff (!rstN)
      (slotEn[n] && !slotChain[n] && !slotSel[n] && !strobe.trigEvt) |=> !preTrig[n]); // R3
  end

  assign preTrig = pulseQ;

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trigEvt |=> (runQ && cntQ == '0)); // R5
  AST_CNT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && cntQ >= modulus && !strobe.trigEvt) |=> !runQ); // R6
endmodule

// File: rtl/pretrig_gen.sv
module pretrig_gen
  import pretrig_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_TRIG  = 4,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TRIG-1:0]  hwTrigIn,
  input  logic [NUM_SLOTS-1:0] convDone,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_SLOTS-1:0] preTrig
);
  logic [NUM_TRIG-1:0]             hwRise;
  logic [NUM_SLOTS-1:0]            slotEn, slotSel, slotChain;
  logic [CNT_W-1:0]                modulus;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] slotDelay;
  ctlStrobe_t                      strobe;

  pretrig_edge #(.NUM_TRIG(NUM_TRIG)) u_edge (
    .clk(clk), .rstN(rstN), .rawIn(hwTrigIn), .riseOut(hwRise)
  );

  pretrig_ctl #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_TRIG(NUM_TRIG), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .hwRise(hwRise),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .slotEn(slotEn), .slotSel(slotSel), .slotChain(slotChain),
    .modulus(modulus), .slotDelay(slotDelay), .strobe(strobe)
  );

  pretrig_dp #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convDone(convDone),
    .slotEn(slotEn), .slotSel(slotSel), .slotChain(slotChain),
    .modulus(modulus), .slotDelay(slotDelay), .preTrig(preTrig)
  );
endmodule

// File: tb/sim_pretrig_gen.sv
module sim_pretrig_gen;
  localparam int M  = 4;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NT-1:0] hwTrigIn = '0;
  logic [M-1:0]  convDone = '0;
  logic          busSel = 1'b0, busWrite = 1'b0;
  logic [3:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [M-1:0]  preTrig;

  pretrig_gen #(.NUM_SLOTS(M), .NUM_TRIG(NT)) u0 (
    .clk(clk), .rstN(rstN), .hwTrigIn(hwTrigIn), .convDone(convDone),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .preTrig(preTrig)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic [M-1:0] mask;
    string       req;
  } exp_t;

  exp_t  expQ[$];
  string idleTag = "R1";
  int    checks = 0, fails = 0;
  bit    monOn = 1'b0, finished = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic expectAt(int at, logic [M-1:0] mask, string req);
    if (expQ.size() > 0 && expQ[expQ.size()-1].at == at)
      expQ[expQ.size()-1].mask |= mask;
    else
      expQ.push_back('{at: at, mask: mask, req: req});
  endtask

  // monitor: pops expected pulses, otherwise expects silence
  logic [M-1:0] monExp;
  string        monReq;
  always @(negedge clk) begin
    if (monOn) begin
      while (expQ.size() > 0 && expQ[0].at < cyc) begin
        check(expQ[0].req, 32'hDEAD, 32'(expQ[0].mask));
        void'(expQ.pop_front());
      end
      monExp = '0;
      monReq = idleTag;
      if (expQ.size() > 0 && expQ[0].at == cyc) begin
        monExp = expQ[0].mask;
        monReq = expQ[0].req;
        void'(expQ.pop_front());
      end
      check(monReq, 32'(preTrig), 32'(monExp));
    end
  end

  task automatic regWr(int a, logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a[3:0]; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic regRd(int a, output logic [31:0] d);
    busAddr = a[3:0];
    #1 d = busRdata;
  endtask

  task automatic swTrig(logic [M-1:0] done);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 4'd2; busWdata = 32'h1;
    convDone = done;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0; convDone = '0;
  endtask

  task automatic pulseDone(logic [M-1:0] done);
    convDone = done;
    @(negedge clk);
    convDone = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    int c, c2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;

    // R1 reset state and field masking
    regRd(0, rd); check("R1", rd, 32'h0);
    regRd(3, rd); check("R6", rd, 32'h0000_FFFF);
    regRd(2, rd); check("R4", rd, 32'h0);
    regWr(0, 32'hFFFF_FFFF);
    regRd(0, rd); check("R1", rd, 32'h000F_0F0F);
    regWr(0, 32'h0);

    // R2 disabled slots stay quiet
    regWr(1, 32'h100);
    idleTag = "R2";
    regWr(0, 32'h0000_0F00);
    swTrig('0); idle(6);
    regWr(0, 32'h0002_0000);
    swTrig('0); pulseDone(4'b0001); idle(3);

    // R4 software trigger, bypass on all slots
    idleTag = "R4";
    regWr(0, 32'h0000_000F);
    c = cyc; expectAt(c + 1, 4'hF, "R4");
    swTrig('0); idle(4);
    regRd(2, rd); check("R4", rd, 32'h0);

    // R5 delayed slot, and restart by a second trigger
    idleTag = "R5";
    regWr(5, 32'd3);
    regWr(0, 32'h0000_0203);
    c = cyc; expectAt(c + 1, 4'h1, "R5"); expectAt(c + 5, 4'h2, "R5");
    swTrig('0); idle(8);
    c = cyc; expectAt(c + 1, 4'h1, "R5");
    swTrig('0);
    c2 = cyc; expectAt(c2 + 1, 4'h1, "R5"); expectAt(c2 + 5, 4'h2, "R5");
    swTrig('0); idle(10);

    // R6 modulus bound
    idleTag = "R6";
    regWr(3, 32'd4); regWr(4, 32'd4); regWr(5, 32'd5);
    regWr(0, 32'h0000_0303);
    c = cyc; expectAt(c + 6, 4'h1, "R6");
    swTrig('0); idle(16);
    regWr(3, 32'h0000_FFFF);

    // R3 hardware trigger path
    idleTag = "R3";
    regWr(1, 32'h002);
    regWr(0, 32'h0000_0001);
    c = cyc; expectAt(c + 3, 4'h1, "R3");
    hwTrigIn = 4'b0110; idle(6); hwTrigIn = '0; idle(3);
    hwTrigIn = 4'b1001; idle(6); hwTrigIn = '0; idle(2);
    regWr(5, 32'd2);
    regWr(0, 32'h0000_0203);
    c = cyc; expectAt(c + 3, 4'h1, "R3"); expectAt(c + 6, 4'h2, "R5");
    hwTrigIn = 4'b0100; idle(10); hwTrigIn = '0; idle(3);

    // R4 cross-mode triggers ignored
    idleTag = "R4";
    swTrig('0); idle(4);
    regWr(1, 32'h102);
    hwTrigIn = 4'b0100; idle(6); hwTrigIn = '0; idle(2);

    // R7 chaining, R8 once per trigger
    idleTag = "R7";
    regWr(0, 32'h0002_0003);
    c = cyc; expectAt(c + 1, 4'h1, "R7");
    swTrig('0); idle(3);
    c = cyc; expectAt(c + 1, 4'h2, "R7");
    pulseDone(4'b0001); idle(3);
    idleTag = "R8";
    pulseDone(4'b0001); idle(3);
    pulseDone(4'b0010); idle(3);

    // R7 wrap from the top slot to slot 0
    idleTag = "R7";
    regWr(0, 32'h0001_0009);
    c = cyc; expectAt(c + 1, 4'h8, "R7");
    swTrig('0); idle(2);
    c = cyc; expectAt(c + 1, 4'h1, "R7");
    pulseDone(4'b1000); idle(3);
    idleTag = "R8";
    pulseDone(4'b1000); idle(3);

    // R9 trigger and conversion-complete in one cycle
    idleTag = "R9";
    regWr(0, 32'h0002_0003);
    c = cyc; expectAt(c + 1, 4'h1, "R9");
    swTrig('0); idle(2);
    c = cyc; expectAt(c + 1, 4'h3, "R9");
    swTrig(4'b0001); idle(2);
    c = cyc; expectAt(c + 1, 4'h2, "R9");
    pulseDone(4'b0001); idle(2);
    c = cyc; expectAt(c + 1, 4'h1, "R9");
    swTrig(4'b0001); idle(2);
    c = cyc; expectAt(c + 1, 4'h2, "R9");
    pulseDone(4'b0001); idle(2);
    idleTag = "R8";
    pulseDone(4'b0001); idle(4);

    check("R8", 32'(expQ.size()), 32'h0);
    monOn = 1'b0;
    summary();
  end
endmodule